// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block sits on the device side of a 16-bit parallel flash interface. It watches the write strobes (active-low chip enable and write enable), turns each completed write into one bus cycle (address plus data), and checks the cycles against fixed multi-cycle unlock sequences. A valid sequence becomes a one-cycle start pulse to the program/erase engine, with the operation kind, the target address and, for a program, the data word.

The same sequence machinery selects what the read path shows: the array, the identification words, or the query table. Any cycle that breaks a sequence sends the decoder back to its idle state and the read path back to the array. While the engine reports busy, every write is dropped with no effect on the sequence state or the read mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, op_start is 0, rd_mode is 0 (array) and id_word is 0.
- R2: Writes of AAh at 5555h, 55h at 2AAAh and A0h at 5555h, followed by one more write, give exactly one op_start with op_kind 1 (program), op_addr equal to that fourth write's address and op_data equal to its full 16-bit data.
- R3: The six-write erase sequence (AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address) starts op_kind 2 (sector) with op_addr bits 17..11 from the last address and bits 10..0 zero.
- R4: The same sequence ending in 50h starts op_kind 3 (block) with op_addr bits 17..15 from the last address and bits 14..0 zero.
- R5: The sequence ending in 10h at 5555h starts op_kind 4 (chip) with op_addr 0 and op_data 0; 10h at any other address starts nothing. Erases always report op_data 0.
- R6: A cycle whose address or low data byte does not match the expected step returns the decoder to idle, so the later steps of that sequence start nothing, and a fresh sequence is accepted afterwards.
- R7: Data bits 15..8 are ignored in every command cycle (all cycles except the program data cycle).
- R8: While busy is 1, completed writes are ignored: no start, no change of sequence state and no change of rd_mode, including for the exit command.
- R9: The three-write prefix ending in 90h at 5555h sets rd_mode to 1 (ID); in that mode id_word is 00BFh at address 0, 2780h at address 1 and 0 at any other address; outside ID mode id_word is 0.
- R10: The prefix ending in 98h at 5555h sets rd_mode to 2 (query); the prefix ending in F0h at 5555h sets rd_mode to 0.
- R11: A cycle that breaks a sequence sets rd_mode to 0 from ID or query mode.
- R12: op_start is high for exactly one clock per accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, synchronous to clk |
| we_n | input | 1 | Write enable, active low, synchronous to clk |
| addr | input | 18 | Word address, also used for ID reads |
| wdata | input | 16 | Write data bus |
| busy | input | 1 | Engine busy with a program or erase |
| op_start | output | 1 | One-cycle operation start pulse |
| op_kind | output | 3 | 1 program, 2 sector, 3 block, 4 chip erase |
| op_addr | output | 18 | Target address of the operation |
| op_data | output | 16 | Program data word (0 for erases) |
| rd_mode | output | 2 | Read source: 0 array, 1 ID, 2 query |
| id_word | output | 16 | ID word for the current address in ID mode |

## Verification
The hardest states to reach are those where a legal command arrives while the engine is busy, because busy is only meaningful after a start and must not disturb a half-entered sequence or the read mode. The bench drives busy itself and issues complete program sequences and the exit command under it, then releases busy and proves with a later read-mode change that nothing was recorded. Aborts are provoked at an early unlock step and at the final erase step with a wrong address, and each is followed by the remaining steps to show they start nothing.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PROG = 3'd1,
    OP_SECT = 3'd2,
    OP_BLK  = 3'd3,
    OP_CHIP = 3'd4
  } op_kind_e;

  typedef enum logic [1:0] {
    RD_ARRAY = 2'd0,
    RD_ID    = 2'd1,
    RD_CFI   = 2'd2
  } rd_mode_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_UNL1 = 3'd1,
    S_UNL2 = 3'd2,
    S_PROG = 3'd3,
    S_ERS1 = 3'd4,
    S_ERS2 = 3'd5,
    S_ERS3 = 3'd6
  } seq_state_e;

  localparam logic [7:0] CODE_KEY1   = 8'hAA;
  localparam logic [7:0] CODE_KEY2   = 8'h55;
  localparam logic [7:0] CODE_PROG   = 8'hA0;
  localparam logic [7:0] CODE_ERASE  = 8'h80;
  localparam logic [7:0] CODE_IDENT  = 8'h90;
  localparam logic [7:0] CODE_QUERY  = 8'h98;
  localparam logic [7:0] CODE_EXIT   = 8'hF0;
  localparam logic [7:0] CODE_SECT   = 8'h30;
  localparam logic [7:0] CODE_BLK    = 8'h50;
  localparam logic [7:0] CODE_CHIP   = 8'h10;

endpackage

// File: rtl/wr_cycle_capture.sv
module wr_cycle_capture #(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          cyc_vld,
  output logic [AW-1:0] cyc_addr,
  output logic [DW-1:0] cyc_data
);

  logic          act;
  logic          act_q;
  logic          lead;
  logic          trail;
  logic [AW-1:0] addr_lat_q;
  logic          vld_q;
  logic [AW-1:0] cyc_addr_q;
  logic [DW-1:0] cyc_data_q;

  assign act   = ~ce_n & ~we_n;
  assign lead  = act & ~act_q;
  assign trail = ~act & act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      act_q <= act;
      vld_q <= trail;
    end
  end

  // address taken when the strobe opens
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lat_q <= '0;
    end else if (lead) begin
      addr_lat_q <= addr;
    end
  end

  // data taken when the strobe closes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_addr_q <= '0;
      cyc_data_q <= '0;
    end else if (trail) begin
      cyc_addr_q <= addr_lat_q;
      cyc_data_q <= wdata;
    end
  end

  assign cyc_vld  = vld_q;
  assign cyc_addr = cyc_addr_q;
  assign cyc_data = cyc_data_q;

endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_vld,
  input  logic [AW-1:0] cyc_addr,
  input  logic [DW-1:0] cyc_data,
  input  logic          busy,
  output logic          op_start,
  output logic [2:0]    op_kind,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          mode_wr,
  output rd_mode_e      mode_val
);

  localparam logic [AW-1:0] ADDR_KEY_A = AW'(16'h5555);
  localparam logic [AW-1:0] ADDR_KEY_B = AW'(16'h2AAA);

  seq_state_e    state_q, state_d;
  logic          start_q, start_d;
  op_kind_e      kind_q, kind_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;

  logic          take;
  logic [7:0]    code;
  logic          at_a;
  logic          at_b;

  assign take = cyc_vld & ~busy;
  assign code = cyc_data[7:0];
  assign at_a = (cyc_addr == ADDR_KEY_A);
  assign at_b = (cyc_addr == ADDR_KEY_B);

  always_comb begin
    state_d  = state_q;
    start_d  = 1'b0;
    kind_d   = kind_q;
    addr_d   = addr_q;
    data_d   = data_q;
    mode_wr  = 1'b0;
    mode_val = RD_ARRAY;
    if (take) begin
      // any mismatch below falls back to idle and array read
      state_d = S_IDLE;
      mode_wr = 1'b1;
      unique case (state_q)
        S_IDLE: begin
          if (at_a && code == CODE_KEY1) begin
            state_d = S_UNL1;
            mode_wr = 1'b0;
          end
        end
        S_UNL1: begin
          if (at_b && code == CODE_KEY2) begin
            state_d = S_UNL2;
            mode_wr = 1'b0;
          end
        end
        S_UNL2: begin
          if (at_a) begin
            unique case (code)
              CODE_PROG:  begin state_d = S_PROG; mode_wr = 1'b0; end
              CODE_ERASE: begin state_d = S_ERS1; mode_wr = 1'b0; end
              CODE_IDENT: mode_val = RD_ID;
              CODE_QUERY: mode_val = RD_CFI;
              default:    mode_val = RD_ARRAY;
            endcase
          end
        end
        S_PROG: begin
          mode_wr = 1'b0;
          start_d = 1'b1;
          kind_d  = OP_PROG;
          addr_d  = cyc_addr;
          data_d  = cyc_data;
        end
        S_ERS1: begin
          if (at_a && code == CODE_KEY1) begin
            state_d = S_ERS2;
            mode_wr = 1'b0;
          end
        end
        S_ERS2: begin
          if (at_b && code == CODE_KEY2) begin
            state_d = S_ERS3;
            mode_wr = 1'b0;
          end
        end
        S_ERS3: begin
          if (code == CODE_SECT) begin
            mode_wr = 1'b0;
            start_d = 1'b1;
            kind_d  = OP_SECT;
            addr_d  = {cyc_addr[AW-1:SECT_LSB], {SECT_LSB{1'b0}}};
            data_d  = '0;
          end else if (code == CODE_BLK) begin
            mode_wr = 1'b0;
            start_d = 1'b1;
            kind_d  = OP_BLK;
            addr_d  = {cyc_addr[AW-1:BLK_LSB], {BLK_LSB{1'b0}}};
            data_d  = '0;
          end else if (code == CODE_CHIP && at_a) begin
            mode_wr = 1'b0;
            start_d = 1'b1;
            kind_d  = OP_CHIP;
            addr_d  = '0;
            data_d  = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      start_q <= 1'b0;
      kind_q  <= OP_NONE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      if (start_d) begin
        kind_q <= kind_d;
        addr_q <= addr_d;
        data_q <= data_d;
      end
    end
  end

  assign op_start = start_q;
  assign op_kind  = kind_q;
  assign op_addr  = addr_q;
  assign op_data  = data_q;

endmodule

// File: rtl/read_mode_ctrl.sv
module read_mode_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int            AW       = 18,
  parameter int            DW       = 16,
  parameter logic [DW-1:0] MFR_WORD = 16'h00BF,
  parameter logic [DW-1:0] DEV_WORD = 16'h2780
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  rd_mode_e      mode_val,
  input  logic [AW-1:0] rd_addr,
  output logic [1:0]    rd_mode,
  output logic [DW-1:0] id_word
);

  rd_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (mode_wr) mode_d = mode_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= RD_ARRAY;
    else        mode_q <= mode_d;
  end

  always_comb begin
    id_word = '0;
    if (mode_q == RD_ID) begin
      if (rd_addr == AW'(0))      id_word = MFR_WORD;
      else if (rd_addr == AW'(1)) id_word = DEV_WORD;
    end
  end

  assign rd_mode = mode_q;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  output logic          op_start,
  output logic [2:0]    op_kind,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic [1:0]    rd_mode,
  output logic [DW-1:0] id_word
);

  localparam int SYNC_DEPTH = 2;

  logic [SYNC_DEPTH-1:0] rst_sync_q;
  logic                  rst_int_n;
  logic                  cyc_vld;
  logic [AW-1:0]         cyc_addr;
  logic [DW-1:0]         cyc_data;
  logic                  mode_wr;
  rd_mode_e              mode_val;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_DEPTH-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_DEPTH-1];

  wr_cycle_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .addr     (addr),
    .wdata    (wdata),
    .cyc_vld  (cyc_vld),
    .cyc_addr (cyc_addr),
    .cyc_data (cyc_data)
  );

  cmd_seq_fsm #(.AW(AW), .DW(DW), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cyc_vld  (cyc_vld),
    .cyc_addr (cyc_addr),
    .cyc_data (cyc_data),
    .busy     (busy),
    .op_start (op_start),
    .op_kind  (op_kind),
    .op_addr  (op_addr),
    .op_data  (op_data),
    .mode_wr  (mode_wr),
    .mode_val (mode_val)
  );

  read_mode_ctrl #(.AW(AW), .DW(DW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .mode_wr  (mode_wr),
    .mode_val (mode_val),
    .rd_addr  (addr),
    .rd_mode  (rd_mode),
    .id_word  (id_word)
  );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          op_start,
  input logic [2:0]    op_kind,
  input logic [AW-1:0] op_addr,
  input logic [DW-1:0] op_data,
  input logic [1:0]    rd_mode,
  input logic [DW-1:0] id_word
);

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start); // R12

  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !op_start); // R8

  AST_BUSY_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(rd_mode)); // R8

  AST_SECT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind == 3'd2) |-> (op_addr[SECT_LSB-1:0] == '0)); // R3

  AST_BLK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind == 3'd3) |-> (op_addr[BLK_LSB-1:0] == '0)); // R4

  AST_CHIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind == 3'd4) |-> (op_addr == '0 && op_data == '0)); // R5

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> (op_kind >= 3'd1 && op_kind <= 3'd4)); // R2

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode != 2'd3); // R10

  AST_ID_ONLY_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode != 2'd1) |-> (id_word == '0)); // R9

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .AW(AW), .DW(DW), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .op_start (op_start),
  .op_kind  (op_kind),
  .op_addr  (op_addr),
  .op_data  (op_data),
  .rd_mode  (rd_mode),
  .id_word  (id_word)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;

  typedef struct packed {
    logic [2:0]  kind;
    logic [17:0] addr;
    logic [15:0] data;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        ce_n;
  logic        we_n;
  logic [17:0] addr;
  logic [15:0] wdata;
  logic        busy;
  logic        op_start;
  logic [2:0]  op_kind;
  logic [17:0] op_addr;
  logic [15:0] op_data;
  logic [1:0]  rd_mode;
  logic [15:0] id_word;

  int   n_chk;
  int   n_err;
  int   n_starts;
  bit   done;
  bit   prev_start;
  exp_t exp_q[$];

  flash_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .wdata(wdata), .busy(busy), .op_start(op_start), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .rd_mode(rd_mode), .id_word(id_word)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string kind_req(input logic [2:0] k);
    case (k)
      3'd1:    return "R2";
      3'd2:    return "R3";
      3'd3:    return "R4";
      default: return "R5";
    endcase
  endfunction

  // monitor: pops expected operations as start pulses appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (op_start) begin
        n_starts++;
        check(!prev_start, "R12", 32'(prev_start), 32'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected start", 32'(op_kind), 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(op_kind == e.kind, kind_req(e.kind), 32'(op_kind), 32'(e.kind));
          check(op_addr == e.addr, kind_req(e.kind), 32'(op_addr), 32'(e.addr));
          check(op_data == e.data, kind_req(e.kind), 32'(op_data), 32'(e.data));
        end
      end
      prev_start = op_start;
    end
  end

  task automatic bus_wr(input logic [17:0] a, input logic [15:0] d);
    @(negedge clk);
    addr  = a;
    wdata = d;
    ce_n  = 1'b0;
    we_n  = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    ce_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic prefix(input logic [7:0] cmd, input logic [7:0] hi);
    bus_wr(18'h05555, {hi, 8'hAA});
    bus_wr(18'h02AAA, {hi, 8'h55});
    bus_wr(18'h05555, {hi, cmd});
  endtask

  task automatic erase_seq(input logic [17:0] a, input logic [7:0] code);
    prefix(8'h80, 8'h00);
    bus_wr(18'h05555, 16'h00AA);
    bus_wr(18'h02AAA, 16'h0055);
    bus_wr(a, {8'h00, code});
  endtask

  task automatic program_op(input logic [17:0] a, input logic [15:0] d, input logic [7:0] hi);
    exp_t e;
    e.kind = 3'd1; e.addr = a; e.data = d;
    exp_q.push_back(e);
    prefix(8'hA0, hi);
    bus_wr(a, d);
  endtask

  task automatic read_id(input logic [17:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    check(id_word == exp, req, 32'(id_word), 32'(exp));
  endtask

  initial begin
    n_chk = 0; n_err = 0; n_starts = 0; done = 1'b0; prev_start = 1'b0;
    ce_n = 1'b1; we_n = 1'b1; addr = '0; wdata = '0; busy = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(op_start == 1'b0, "R1", 32'(op_start), 32'd0);
    check(rd_mode == 2'd0, "R1", 32'(rd_mode), 32'd0);
    check(id_word == 16'h0, "R1", 32'(id_word), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 program, R7 junk high byte in command cycles
    program_op(18'h12345, 16'hBEEF, 8'h00);
    program_op(18'h3FFFF, 16'hA5A5, 8'hC3);

    // R3 sector, R4 block, R5 chip
    begin
      exp_t e;
      e.kind = 3'd2; e.addr = {7'h7F, 11'h0}; e.data = 16'h0; exp_q.push_back(e);
      erase_seq(18'h3F8A5, 8'h30);
      e.kind = 3'd3; e.addr = {3'h5, 15'h0}; e.data = 16'h0; exp_q.push_back(e);
      erase_seq(18'h2ABCD, 8'h50);
      e.kind = 3'd4; e.addr = 18'h0; e.data = 16'h0; exp_q.push_back(e);
      erase_seq(18'h05555, 8'h10);
    end
    check(n_starts == 5, "R2", 32'(n_starts), 32'd5);

    // R5 chip code at wrong address starts nothing
    erase_seq(18'h01234, 8'h10);
    check(n_starts == 5, "R5", 32'(n_starts), 32'd5);

    // R6 broken second step, then the rest of a program sequence
    bus_wr(18'h05555, 16'h00AA);
    bus_wr(18'h02AAA, 16'h0056);
    bus_wr(18'h05555, 16'h00A0);
    bus_wr(18'h00100, 16'h1234);
    check(n_starts == 5, "R6", 32'(n_starts), 32'd5);
    program_op(18'h00200, 16'h0F0F, 8'h00);
    check(n_starts == 6, "R6", 32'(n_starts), 32'd6);

    // R9 ID mode and words
    prefix(8'h90, 8'h7E);
    check(rd_mode == 2'd1, "R9", 32'(rd_mode), 32'd1);
    read_id(18'h00000, 16'h00BF, "R9");
    read_id(18'h00001, 16'h2780, "R9");
    read_id(18'h00005, 16'h0000, "R9");

    // R8 exit ignored while busy, program ignored while busy
    busy = 1'b1;
    prefix(8'hF0, 8'h00);
    check(rd_mode == 2'd1, "R8", 32'(rd_mode), 32'd1);
    prefix(8'hA0, 8'h00);
    bus_wr(18'h00333, 16'h4444);
    check(n_starts == 6, "R8", 32'(n_starts), 32'd6);
    busy = 1'b0;
    repeat (2) @(negedge clk);
    check(rd_mode == 2'd1, "R8", 32'(rd_mode), 32'd1);

    // R10 exit, then query mode
    prefix(8'hF0, 8'h00);
    check(rd_mode == 2'd0, "R10", 32'(rd_mode), 32'd0);
    read_id(18'h00000, 16'h0000, "R9");
    prefix(8'h98, 8'h00);
    check(rd_mode == 2'd2, "R10", 32'(rd_mode), 32'd2);

    // R11 stray write leaves query mode
    bus_wr(18'h01234, 16'h0000);
    check(rd_mode == 2'd0, "R11", 32'(rd_mode), 32'd0);
    prefix(8'h90, 8'h00);
    bus_wr(18'h05555, 16'h0077);
    check(rd_mode == 2'd0, "R11", 32'(rd_mode), 32'd0);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R2 pending starts", 32'(exp_q.size()), 32'd0);
    check(n_starts == 6, "R12", 32'(n_starts), 32'd6);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule